// File: doc/BRIEF.md
# Long-Lag XOR Decorrelator

This block takes a raw stream of random bits, one bit per strobe, and removes short-range correlation from it. Each output bit is the XOR of two raw bits that lie a full lag depth apart in the raw stream. Neighbouring raw samples from a physical noise source tend to take opposite values, so XOR-ing neighbours would add bias rather than remove it. A wide separation avoids that.

Accepted raw bits are counted by a wrapping index over a one-bit-wide ring store of `LAG_DEPTH` entries, with 4096 as the default. The block alternates between two phases of `LAG_DEPTH` accepted bits each. In the store phase every accepted bit is written at the current index and nothing is emitted. In the pair phase every accepted bit is XOR-ed with the stored bit at the same index, and the result is emitted in the same cycle. Each raw bit is used exactly once, so the output rate is half the input rate. A synchronous flush restarts the pairing from an empty store.

Top module: `lag_xor_decorr`

## Requirements
- R1: After reset, `out_valid` is low, and the first `LAG_DEPTH` accepted raw bits produce no output.
- R2: `out_valid` is high for exactly one cycle per output bit. It is high only in a cycle where `raw_valid` is high, `flush` is low and the block is in its pair phase.
- R3: In the pair phase, the k-th accepted bit (k counted from 0) gives `out_bit` = that bit XOR the k-th bit accepted in the store phase just before. The two bits are therefore exactly `LAG_DEPTH` positions apart, and adjacent raw bits are never combined.
- R4: The phases alternate after every `LAG_DEPTH` accepted bits: store, pair, store, pair. Exactly one output is produced for every two accepted raw bits.
- R5: Cycles with `raw_valid` low neither advance the pairing nor produce output.
- R6: A cycle with `flush` high returns the block to the start of a store phase at index 0. The next `LAG_DEPTH` accepted bits produce no output, and later pairs use only bits accepted after the flush.
- R7: When `flush` and `raw_valid` are high in the same cycle, the flush wins. That raw bit is discarded and `out_valid` stays low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| flush | input | 1 | Synchronous restart of the pairing from an empty store |
| raw_valid | input | 1 | Raw bit strobe |
| raw_bit | input | 1 | Raw random bit |
| out_valid | output | 1 | Output bit strobe, one cycle per output bit |
| out_bit | output | 1 | Decorrelated bit (0 when `out_valid` is low) |

## Verification
The pairing is driven with all-zero and all-one streams, with a strictly alternating stream and with a pseudo-random sequence. Some runs are continuous and some have idle gaps.

- The constant streams expose a wrong XOR polarity or a stuck output.
- The alternating stream gives all zeros only when partners sit an even lag apart; a design that paired neighbours would emit all ones.
- The pseudo-random stream catches any index skew between the stored bit and its partner.
- The gapped runs show that idle cycles do not advance the index.

Directed tests cover the first fill after reset, a flush in the middle of a store phase, and a flush that coincides with a pair-phase bit.

// File: rtl/lag_xor_pkg.sv
package lag_xor_pkg;

  typedef enum logic {
    PH_STORE = 1'b0,
    PH_PAIR  = 1'b1
  } lag_phase_e;

endpackage

// File: rtl/lxd_rst_sync.sv
module lxd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lxd_index_ctrl.sv
module lxd_index_ctrl
  import lag_xor_pkg::*;
#(
  parameter int LAG_DEPTH = 4096,
  localparam int IDX_W = (LAG_DEPTH > 1) ? $clog2(LAG_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             flush,
  output logic [IDX_W-1:0] idx,
  output lag_phase_e       phase
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAG_DEPTH - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  lag_phase_e       phase_q, phase_d;
  logic             state_en;

  // next state
  always_comb begin
    idx_d    = idx_q;
    phase_d  = phase_q;
    state_en = 1'b0;
    if (flush) begin
      idx_d    = '0;
      phase_d  = PH_STORE;
      state_en = 1'b1;
    end else if (accept) begin
      state_en = 1'b1;
      if (idx_q == LAST_IDX) begin
        idx_d   = '0;
        phase_d = (phase_q == PH_STORE) ? PH_PAIR : PH_STORE;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_STORE;
    end else if (state_en) begin
      idx_q   <= idx_d;
      phase_q <= phase_d;
    end
  end

  assign idx   = idx_q;
  assign phase = phase_q;

  // R5: an idle cycle leaves the pairing position untouched
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !flush) |=> ($stable(idx_q) && $stable(phase_q)));

  // R6: a flush lands at index 0 of a store phase
  p_flush_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (idx_q == '0 && phase_q == PH_STORE));

  // R4: the phase flips when an accepted bit wraps the index
  p_wrap_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !flush && idx_q == LAST_IDX) |=> (phase_q != $past(phase_q) && idx_q == '0));

  // R4: the phase holds while the index has not wrapped
  p_phase_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && idx_q != LAST_IDX) |=> $stable(phase_q));

endmodule

// File: rtl/lxd_ring_store.sv
module lxd_ring_store #(
  parameter int LAG_DEPTH = 4096,
  localparam int IDX_W = (LAG_DEPTH > 1) ? $clog2(LAG_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_bit,
  output logic             rd_bit
);

  logic [LAG_DEPTH-1:0] store_q;

  // storage array, no reset (contents are rewritten before each use)
  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[idx] <= wr_bit;
    end
  end

  assign rd_bit = store_q[idx];

endmodule

// File: rtl/lxd_pair_xor.sv
module lxd_pair_xor
  import lag_xor_pkg::*;
(
  input  logic       raw_valid,
  input  logic       flush,
  input  lag_phase_e phase,
  input  logic       raw_bit,
  input  logic       partner_bit,
  output logic       out_valid,
  output logic       out_bit
);

  always_comb begin
    out_valid = raw_valid && !flush && (phase == PH_PAIR);
    out_bit   = out_valid ? (raw_bit ^ partner_bit) : 1'b0;
  end

endmodule

// File: rtl/lag_xor_decorr.sv
module lag_xor_decorr
  import lag_xor_pkg::*;
#(
  parameter int LAG_DEPTH = 4096,
  localparam int IDX_W = (LAG_DEPTH > 1) ? $clog2(LAG_DEPTH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic raw_valid,
  input  logic raw_bit,
  output logic out_valid,
  output logic out_bit
);

  logic             rst_sync_n;
  logic             accept;
  logic             store_wr;
  logic             partner_bit;
  logic [IDX_W-1:0] idx;
  lag_phase_e       phase;

  lxd_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign accept   = raw_valid && rst_sync_n;
  assign store_wr = accept && !flush && (phase == PH_STORE);

  lxd_index_ctrl #(.LAG_DEPTH(LAG_DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .accept (accept),
    .flush  (flush),
    .idx    (idx),
    .phase  (phase)
  );

  lxd_ring_store #(.LAG_DEPTH(LAG_DEPTH)) u_store (
    .clk    (clk),
    .wr_en  (store_wr),
    .idx    (idx),
    .wr_bit (raw_bit),
    .rd_bit (partner_bit)
  );

  lxd_pair_xor u_xor (
    .raw_valid   (accept),
    .flush       (flush),
    .phase       (phase),
    .raw_bit     (raw_bit),
    .partner_bit (partner_bit),
    .out_valid   (out_valid),
    .out_bit     (out_bit)
  );

  // R1: nothing is emitted while the store phase is running
  p_silent_store_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_STORE) |-> !out_valid);

  // R2: every output needs an incoming raw strobe
  p_out_needs_in_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> raw_valid);

  // R7: flush suppresses the output of a coinciding bit
  p_flush_blocks_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |-> !out_valid);

  // R3: a pair-phase bit never overwrites its stored partner
  p_no_pair_write_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> !store_wr);

endmodule

// File: tb/lag_xor_decorr_bench.sv
module lag_xor_decorr_bench;

  localparam int LAG = 4096;
  localparam int WATCHDOG = 150000;

  // table entry: {pattern mode[1:0], idle gap period[3:0], lfsr seed[15:0]}
  // mode 0 all zero, 1 all one, 2 alternating, 3 pseudo-random
  localparam int NVEC = 6;
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd0, 4'd0, 16'h0001},
    {2'd1, 4'd0, 16'h0001},
    {2'd2, 4'd0, 16'h0001},
    {2'd3, 4'd0, 16'hACE1},
    {2'd3, 4'd5, 16'h1D2B},
    {2'd2, 4'd3, 16'h0001}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic flush, raw_valid, raw_bit;
  logic out_valid, out_bit;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit hist [LAG];
  logic [15:0] lfsr;

  always #2.5 clk = ~clk;

  lag_xor_decorr #(.LAG_DEPTH(LAG)) u_lag_xor_decorr (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .raw_valid (raw_valid),
    .raw_bit   (raw_bit),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic v, input logic b, input logic f,
                      input logic exp_v, input logic exp_b, input string req);
    @(negedge clk);
    raw_valid = v;
    raw_bit   = b;
    flush     = f;
    #1;
    checks++;
    if (out_valid !== exp_v || (exp_v && out_bit !== exp_b)) begin
      errors++;
      $display("FAIL %s: actual valid=%b bit=%b expected valid=%b bit=%b",
               req, out_valid, out_bit, exp_v, exp_b);
    end
  endtask

  function automatic logic next_bit(input logic [1:0] mode, input int n);
    case (mode)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return logic'(n[0]);
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
      end
    endcase
  endfunction

  // one full store phase then one pair phase, optional idle gaps (R5)
  task automatic run_pattern(input logic [1:0] mode, input int gap, input string tag);
    for (int n = 0; n < 2 * LAG; n++) begin
      logic b;
      int k;
      b = next_bit(mode, n);
      k = n % LAG;
      if (n < LAG) begin
        hist[k] = b;
        step(1'b1, b, 1'b0, 1'b0, 1'b0, {tag, " store phase silent R4"});
      end else begin
        step(1'b1, b, 1'b0, 1'b1, b ^ hist[k], {tag, " pair XOR at lag R3"});
      end
      if (gap != 0 && (n % gap) == gap - 1)
        step(1'b0, ~b, 1'b0, 1'b0, 1'b0, {tag, " idle no output R5"});
    end
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; raw_valid = 1'b0; raw_bit = 1'b0;
    lfsr = 16'h0001;
    repeat (3) @(negedge clk);
    // R1: output quiet during reset even with strobe high
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "reset quiet R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "after reset R1");

    // R1: first fill after reset, then pairing (alternating, R3 separation)
    run_pattern(2'd2, 0, "post-reset R1");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      lfsr = VEC[i][15:0];
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "flush before vector R6");
      run_pattern(VEC[i][21:20], int'(VEC[i][19:16]), $sformatf("vec%0d R2", i));
    end

    // R6: flush mid-store, old bits must not be paired
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "flush R6");
    for (int n = 0; n < 100; n++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "pre-flush store R6");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "mid flush R6");
    lfsr = 16'h3C5A;
    run_pattern(2'd3, 0, "post-flush R6");

    // R7: flush coincides with a pair-phase bit
    lfsr = 16'h0F0F;
    for (int n = 0; n < LAG; n++) begin
      logic b;
      b = next_bit(2'd3, n);
      hist[n] = b;
      step(1'b1, b, 1'b0, 1'b0, 1'b0, "store before R7");
    end
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "flush beats strobe R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "store restarts after R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule